// File: doc/BRIEF.md
# Serial Command Frame Decoder

This block sits behind a byte-oriented serial receiver and turns a short, fixed command into two settings for a phase-accumulator tone generator: an 8-bit waveform selector and a 32-bit tuning word. Each received byte arrives with a one-cycle strobe. While no frame is open, the decoder discards every byte except the opcode 0x01. Once that opcode arrives, the next byte becomes the waveform selector. The four bytes after it build the tuning word, most significant byte first. After the last of them the decoder closes the frame and waits for a new opcode.

The tuning word is built in a private working register and copied to the output in a single step when the frame's final byte lands. The downstream accumulator therefore never adds a half-loaded increment. An optional silence timer closes a half-received frame after a set number of strobe-free cycles, so a lost byte costs one frame and does not shift every later frame. At 200 MHz, the default of 200000 cycles gives about 1 ms.

Top module: `cmd_frame_decoder`

## Requirements
- R1: Reset sets the waveform selector to 0 and the tuning word to 1073741 (0x0010624D).
- R2: With no frame open, a strobed byte equal to 0x01 opens a frame. Any other strobed byte changes neither output, and the decoder still waits for 0x01.
- R3: A byte presented while the strobe is low has no effect on either output or on frame progress, even when its value is 0x01.
- R4: The first strobed byte after the opcode (frame byte 2) appears on the waveform selector one clock after its strobe.
- R5: Frame bytes 3 to 6 form the tuning word as byte3<<24 | byte4<<16 | byte5<<8 | byte6.
- R6: The tuning word keeps its previous value while frame bytes 3 to 5 arrive and changes only in the clock after byte 6. The waveform selector does not change during bytes 3 to 6.
- R7: After byte 6 the frame is closed, and a following non-opcode byte is discarded.
- R8: The value 0x01 inside a frame (bytes 2 to 6) is treated as data and is never taken as an opcode.
- R9: When TIMEOUT_CYCLES is nonzero, an open frame that sees TIMEOUT_CYCLES consecutive strobe-free cycles is closed. Its partial tuning bytes are discarded, and the tuning word keeps its old value. A gap one cycle shorter leaves the frame open.
- R10: Strobes on consecutive clocks are each accepted as a separate byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_byte | input | DATA_W | Received byte, valid when rx_valid is high |
| wave_sel | output | DATA_W | Waveform selector register |
| tune_word | output | DATA_W*WORD_BYTES | Tuning word register, updated whole |

## Verification
The first pattern is a back-to-back frame with distinct byte values. It shows the byte order of the tuning word and whether every strobe is counted. The second is a frame whose bytes are spread over a few idle cycles and which carries 0x01 as data. It separates data from opcode and shows that strobe-free cycles are ignored. Further patterns check that junk bytes before and after a frame are discarded, and that a gap exactly at the silence limit closes a frame while a gap one cycle shorter does not. The bench compares both outputs against a behavioural model on every clock across all of these patterns.

// File: rtl/cmdfrm_pkg.sv
package cmdfrm_pkg;
   // Frame position codes; the tuning-byte positions follow WAVE upward.
   localparam int POS_IDLE  = 0;
   localparam int POS_WAVE  = 1;
   localparam int POS_WORD0 = 2;

   function automatic int pos_bits(input int word_bytes);
      return $clog2(word_bytes + 2);
   endfunction
endpackage

// File: rtl/frame_sequencer.sv
module frame_sequencer
   import cmdfrm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int WORD_BYTES = 4,
   parameter logic [DATA_W-1:0] OPCODE = 'h01,
   localparam int SW = pos_bits(WORD_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              abort,
   output logic [SW-1:0]     pos,
   output logic              busy,
   output logic              wave_load,
   output logic              word_shift,
   output logic              word_done
);
   localparam logic [SW-1:0] P_IDLE  = SW'(POS_IDLE);
   localparam logic [SW-1:0] P_WAVE  = SW'(POS_WAVE);
   localparam logic [SW-1:0] P_WORD0 = SW'(POS_WORD0);
   localparam logic [SW-1:0] P_LAST  = SW'(POS_WORD0 + WORD_BYTES - 1);

   logic [SW-1:0] pos_nxt;
   logic          in_word;
   logic          legal;

   always_comb begin
      in_word    = (pos >= P_WORD0) && (pos <= P_LAST);
      legal      = (pos <= P_LAST);
      busy       = (pos != P_IDLE);
      wave_load  = rx_valid && (pos == P_WAVE);
      word_shift = rx_valid && in_word;
      word_done  = rx_valid && (pos == P_LAST);
      pos_nxt    = pos;
      if (!legal) begin
         pos_nxt = P_IDLE;
      end else if (rx_valid) begin
         if (pos == P_IDLE)
            pos_nxt = (rx_byte == OPCODE) ? P_WAVE : P_IDLE;
         else if (pos == P_LAST)
            pos_nxt = P_IDLE;
         else
            pos_nxt = pos + 1'b1;
      end else if (abort) begin
         pos_nxt = P_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos <= P_IDLE;
      else        pos <= pos_nxt;
   end
endmodule

// File: rtl/word_assembler.sv
module word_assembler #(
   parameter int DATA_W = 8,
   parameter int WORD_BYTES = 4,
   localparam int WORD_W = DATA_W * WORD_BYTES,
   parameter logic [WORD_W-1:0] WORD_RESET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              done,
   input  logic [DATA_W-1:0] din,
   output logic [WORD_W-1:0] word_out
);
   logic [WORD_W-1:0] work;
   logic [WORD_W-1:0] work_nxt;

   // shift left one byte and add the new one
   always_comb work_nxt = (work << DATA_W) + WORD_W'(din);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work     <= '0;
         word_out <= WORD_RESET;
      end else begin
         if (shift_en) work <= work_nxt;
         if (done)     word_out <= work_nxt;
      end
   end
endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
   parameter int TIMEOUT_CYCLES = 200000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic rx_valid,
   output logic abort
);
   generate
      if (TIMEOUT_CYCLES == 0) begin : g_off
         logic unused_in;
         assign unused_in = ^{clk, rst_n, busy, rx_valid};
         assign abort = 1'b0;
      end else begin : g_on
         localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
         localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES - 1);
         logic [CW-1:0] quiet;

         assign abort = busy && !rx_valid && (quiet == LIMIT);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                quiet <= '0;
            else if (rx_valid || !busy) quiet <= '0;
            else if (abort)            quiet <= '0;
            else                       quiet <= quiet + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder
   import cmdfrm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int WORD_BYTES = 4,
   parameter logic [DATA_W-1:0] OPCODE = 'h01,
   parameter logic [DATA_W-1:0] WAVE_RESET = '0,
   parameter logic [DATA_W*WORD_BYTES-1:0] WORD_RESET = 'd1073741,
   parameter int TIMEOUT_CYCLES = 200000
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rx_valid,
   input  logic [DATA_W-1:0]            rx_byte,
   output logic [DATA_W-1:0]            wave_sel,
   output logic [DATA_W*WORD_BYTES-1:0] tune_word
);
   localparam int SW = pos_bits(WORD_BYTES);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (WORD_BYTES < 1) begin : g_bad_bytes
         $error("WORD_BYTES must be at least 1");
      end
      if (TIMEOUT_CYCLES < 0) begin : g_bad_timeout
         $error("TIMEOUT_CYCLES must not be negative");
      end
   endgenerate

   logic [SW-1:0] seq_pos;
   logic          seq_busy;
   logic          wave_load;
   logic          word_shift;
   logic          word_done;
   logic          gap_abort;

   frame_sequencer #(
      .DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES), .OPCODE(OPCODE)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .abort(gap_abort), .pos(seq_pos), .busy(seq_busy),
      .wave_load(wave_load), .word_shift(word_shift), .word_done(word_done)
   );

   word_assembler #(
      .DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES), .WORD_RESET(WORD_RESET)
   ) u_word (
      .clk(clk), .rst_n(rst_n), .shift_en(word_shift), .done(word_done),
      .din(rx_byte), .word_out(tune_word)
   );

   gap_timer #(
      .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
   ) u_gap (
      .clk(clk), .rst_n(rst_n), .busy(seq_busy), .rx_valid(rx_valid),
      .abort(gap_abort)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         wave_sel <= WAVE_RESET;
      else if (wave_load) wave_sel <= rx_byte;
   end
endmodule

// File: rtl/frame_checker.sv
module frame_checker
   import cmdfrm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int WORD_BYTES = 4,
   parameter logic [DATA_W-1:0] OPCODE = 'h01,
   localparam int SW = pos_bits(WORD_BYTES)
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         rx_valid,
   input logic [DATA_W-1:0]            rx_byte,
   input logic [SW-1:0]                pos,
   input logic                         abort,
   input logic [DATA_W-1:0]            wave_sel,
   input logic [DATA_W*WORD_BYTES-1:0] tune_word
);
   localparam logic [SW-1:0] P_IDLE = SW'(POS_IDLE);
   localparam logic [SW-1:0] P_WAVE = SW'(POS_WAVE);
   localparam logic [SW-1:0] P_LAST = SW'(POS_WORD0 + WORD_BYTES - 1);

   // R2
   idle_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos == P_IDLE && rx_valid && rx_byte != OPCODE) |=> pos == P_IDLE);
   // R2
   idle_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos == P_IDLE && rx_valid && rx_byte == OPCODE) |=> pos == P_WAVE);
   // R3
   hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_valid && !abort) |=> $stable(pos));
   // R3
   wave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> $stable(wave_sel));
   // R4
   wave_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos == P_WAVE && rx_valid) |=> wave_sel == $past(rx_byte));
   // R6
   tune_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && pos == P_LAST) |=> $stable(tune_word));
   // R7
   frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos == P_LAST && rx_valid) |=> pos == P_IDLE);
   // R7
   legal_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pos <= P_LAST);
   // R9
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> pos == P_IDLE);
endmodule

bind cmd_frame_decoder frame_checker #(
   .DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES), .OPCODE(OPCODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
   .pos(seq_pos), .abort(gap_abort), .wave_sel(wave_sel), .tune_word(tune_word)
);

// File: tb/cmd_frame_decoder_test.sv
module cmd_frame_decoder_test;
   localparam int CLK_PERIOD = 10;
   localparam int GAP = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic [7:0]  wave_sel;
   logic [31:0] tune_word;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmd_frame_decoder #(.TIMEOUT_CYCLES(GAP)) uut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .wave_sel(wave_sel), .tune_word(tune_word)
   );

   int    total = 0;
   int    bad = 0;
   bit    finished = 1'b0;
   string req = "R1";

   // behavioural reference: phase 0 = waiting, 1 = expect selector, 2 = collecting word
   int          m_phase;
   int          m_quiet;
   logic [7:0]  m_wave;
   logic [31:0] m_tune;
   logic [7:0]  m_bytes[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0; m_quiet = 0; m_wave = 8'h00; m_tune = 32'd1073741;
         m_bytes.delete();
      end else if (rx_valid) begin
         m_quiet = 0;
         if (m_phase == 0) begin
            if (rx_byte == 8'h01) m_phase = 1;
         end else if (m_phase == 1) begin
            m_wave = rx_byte; m_phase = 2;
         end else begin
            m_bytes.push_back(rx_byte);
            if (m_bytes.size() == 4) begin
               m_tune = {m_bytes[0], m_bytes[1], m_bytes[2], m_bytes[3]};
               m_bytes.delete();
               m_phase = 0;
            end
         end
      end else if (m_phase != 0) begin
         m_quiet++;
         if (m_quiet == GAP) begin
            m_phase = 0; m_quiet = 0; m_bytes.delete();
         end
      end
   end

   task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", r, act, exp);
      end
   endtask

   task automatic tick(input bit v, input logic [7:0] b);
      @(negedge clk);
      check(req, {24'h0, wave_sel}, {24'h0, m_wave});
      check(req, tune_word, m_tune);
      rx_valid = v;
      rx_byte = b;
   endtask

   task automatic quiet(input int n);
      for (int i = 0; i < n; i++) tick(1'b0, 8'h01);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got running expected done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      check("R1", {24'h0, wave_sel}, 32'h0);
      check("R1", tune_word, 32'h0010624D);

      // R2 junk bytes in idle are dropped
      req = "R2";
      tick(1, 8'h55); tick(1, 8'h00); tick(1, 8'hFF); tick(0, 8'h00);
      check("R2", {24'h0, wave_sel}, 32'h0);
      // R3 a non-strobed opcode does not open a frame
      req = "R3";
      tick(0, 8'h01); tick(1, 8'h22); tick(0, 8'h00);
      check("R3", {24'h0, wave_sel}, 32'h0);

      // R10 back-to-back frame, R4 selector, R5 byte order, R6 shadowing
      req = "R10";
      tick(1, 8'h01); tick(1, 8'h03); tick(1, 8'h12); tick(1, 8'h34); tick(1, 8'h56);
      check("R4", {24'h0, wave_sel}, 32'h3);
      tick(1, 8'h78);
      check("R6", tune_word, 32'h0010624D);
      check("R6", {24'h0, wave_sel}, 32'h3);
      tick(0, 8'h00);
      check("R5", tune_word, 32'h12345678);

      // R7 byte after a closed frame is dropped
      req = "R7";
      tick(1, 8'h09); tick(1, 8'h44); tick(0, 8'h00);
      check("R7", {24'h0, wave_sel}, 32'h3);

      // R8 opcode value as data, bytes spread with short gaps
      req = "R8";
      tick(1, 8'h01); quiet(5);
      tick(1, 8'h01); quiet(5);
      tick(1, 8'h01); quiet(3);
      tick(1, 8'h02); quiet(4);
      tick(1, 8'h03); quiet(2);
      tick(1, 8'h04); tick(0, 8'h00);
      check("R8", {24'h0, wave_sel}, 32'h1);
      check("R8", tune_word, 32'h01020304);

      // R9 gap of GAP cycles drops the partial frame
      req = "R9";
      tick(1, 8'h01); tick(1, 8'h06); tick(1, 8'hAA); tick(1, 8'hBB);
      quiet(GAP);
      tick(1, 8'hCC); tick(1, 8'hDD); tick(1, 8'hEE); tick(1, 8'hFF); tick(0, 8'h00);
      check("R9", {24'h0, wave_sel}, 32'h6);
      check("R9", tune_word, 32'h01020304);
      // R9 gap of GAP-1 keeps the frame open
      tick(1, 8'h01); tick(1, 8'h07); quiet(GAP - 1);
      tick(1, 8'hA1); quiet(GAP - 1);
      tick(1, 8'hB2); tick(1, 8'hC3); quiet(GAP - 1);
      tick(1, 8'hD4); tick(0, 8'h00);
      check("R9", {24'h0, wave_sel}, 32'h7);
      check("R9", tune_word, 32'hA1B2C3D4);

      quiet(4);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule